// File: doc/BRIEF.md
# I/O-Mapped DAC Command Decoder

This block sits between an 8-bit processor I/O bus and a 16-bit voltage-output DAC whose input latch is loaded one byte at a time. The block watches write cycles and decodes a block of eight port addresses. Six of those addresses act as commands. Each decoded command becomes one strobe on the DAC side: a low-byte load, a high-byte load, an output update, a clear to unipolar zero, or a clear to bipolar zero. The DAC's serial/byte mode select is held in byte mode.

The three low address bits form the command offset. Bits [2:1] pick the command class: 00 loads the input register, 01 updates the output, 10 clears. Bit [0] picks the byte for a load (0 is low, 1 is high) or the clear target (0 is unipolar, 1 is bipolar). `BASE_ADDR` places the block in the port map. Its low three bits are ignored. More DAC channels can be added by instancing the block at other bases.

Every strobe is registered in the system clock domain. It lasts as long as the qualified write, and never less than `MIN_STROBE` clocks. The low-byte enable also carries the clear target. That level is set up one clock before the clear strobe begins.

Top module: `io_dac_cmd_decoder`

## Requirements
- R1: A command is decoded only while both `iorq_ni` and `wr_ni` are low. If either one stays high for the whole cycle, no strobe is produced.
- R2: A write to offset 0 drives `cs_no` and `lbe_no` low together, while `hbe_no` stays high.
- R3: A write to offset 1 drives `cs_no` and `hbe_no` low together, while `lbe_no` stays high.
- R4: A write to offset 2 or 3 drives `ldac_o` high. `cs_no`, `hbe_no` and `lbe_no` stay high.
- R5: A write to offset 4 or 5 drives `clr_no` low. The clear target appears on `lbe_no`: low (0) at offset 4 means unipolar zero, and high (1) at offset 5 means bipolar zero.
- R6: For a clear, `lbe_no` takes the target level exactly one clock before `clr_no` falls. It holds that level for every clock of the clear and returns high when the clear ends.
- R7: Strobe timing is defined from the first rising clock edge that sees a qualified write. Byte and update strobes start two edges after that edge, and a clear strobe starts three edges after it. Every strobe lasts max(N, `MIN_STROBE`) clocks, where N is the number of edges that saw the write.
- R8: Offsets 6 and 7 produce no strobe, and neither does any address whose bits above bit 2 differ from `BASE_ADDR`.
- R9: `dac_data_o` shows the byte of a load from the first clock of its strobe and holds it stable until the next load. Data written to offsets 2 to 5, or to an ignored address, leaves it unchanged.
- R10: At most one of the byte-load, update and clear strobes is active at a time. `hbe_no` and `lbe_no` are never low together. `hbe_no` is low only while `cs_no` is low. `byte_mode_o` is always high.
- R11: After reset, `cs_no`, `hbe_no`, `lbe_no` and `clr_no` are high, `ldac_o` is low, and `dac_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | I/O port address |
| iorq_ni | input | 1 | I/O request strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Write data bus |
| cs_no | output | 1 | DAC chip select for byte loads, active low |
| hbe_no | output | 1 | High-byte enable, active low |
| lbe_no | output | 1 | Low-byte enable, active low; carries the clear target during a clear |
| ldac_o | output | 1 | DAC output update, active high |
| clr_no | output | 1 | DAC clear, active low |
| dac_data_o | output | 8 | Byte presented to the DAC data pins |
| byte_mode_o | output | 1 | Serial/byte select held high for byte mode |

## Verification
The bench goes after one-clock writes, which test the minimum-length stretch. A design that fails to stretch them gives a single-clock strobe that the DAC may miss. Clears in both targets are checked clock by clock on `lbe_no`. A design without the setup clock, or one that drops the level early, clears to the wrong zero. Half-qualified cycles, offsets 6 and 7, and neighbouring bases must stay silent. A decoder that ignores a strobe or the upper address bits would fire spurious loads. Writes to the update and clear offsets carry random data, so a data path that latches on every hit is caught on `dac_data_o`.

// File: rtl/io_dac_cmd_pkg.sv
package io_dac_cmd_pkg;
  localparam int unsigned DAC_BYTE_W = 8;
  localparam int unsigned OFS_W      = 3;
  localparam int unsigned CMD_SLOTS  = 6;

  typedef enum logic [1:0] {
    OP_BYTE   = 2'b00,
    OP_UPDATE = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_NONE   = 2'b11
  } op_e;

  typedef struct packed {
    logic                  valid;
    op_e                   op;
    logic                  sel;   // byte: 1=high; clear: 1=bipolar
    logic [DAC_BYTE_W-1:0] data;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYTE,
    ST_UPD,
    ST_SETUP,
    ST_CLR
  } seq_state_e;
endpackage

// File: rtl/io_dac_addr_decode.sv
module io_dac_addr_decode
  import io_dac_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h40
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  iorq_ni,
  input  logic                  wr_ni,
  input  logic [DAC_BYTE_W-1:0] data_i,
  output cmd_t                  cmd_o
);
  localparam logic [ADDR_W-1:0] BaseV = ADDR_W'(BASE_ADDR);

  logic [OFS_W-1:0] ofs;
  logic             in_block;
  logic             slot_ok;

  assign ofs      = addr_i[OFS_W-1:0];
  assign in_block = (addr_i[ADDR_W-1:OFS_W] == BaseV[ADDR_W-1:OFS_W]);
  assign slot_ok  = (32'(ofs) < CMD_SLOTS);

  always_comb begin
    cmd_o.valid = in_block && slot_ok && !iorq_ni && !wr_ni;
    cmd_o.sel   = ofs[0];
    cmd_o.data  = data_i;
    unique case (ofs[2:1])
      2'b00:   cmd_o.op = OP_BYTE;
      2'b01:   cmd_o.op = OP_UPDATE;
      2'b10:   cmd_o.op = OP_CLEAR;
      default: cmd_o.op = OP_NONE;
    endcase
    if (!cmd_o.valid) cmd_o.op = OP_NONE;
  end
endmodule

// File: rtl/io_dac_bus_capture.sv
module io_dac_bus_capture
  import io_dac_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_t cmd_i,
  output cmd_t cmd_q_o,
  output logic valid_qq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q_o    <= '{valid: 1'b0, op: OP_NONE, sel: 1'b0, data: '0};
      valid_qq_o <= 1'b0;
    end else begin
      cmd_q_o    <= cmd_i;
      valid_qq_o <= cmd_q_o.valid;
    end
  end
endmodule

// File: rtl/io_dac_strobe_seq.sv
module io_dac_strobe_seq
  import io_dac_cmd_pkg::*;
#(
  parameter int unsigned MIN_STROBE = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  cmd_t                  cmd_i,
  input  logic                  valid_qq_i,
  output logic                  cs_no,
  output logic                  hbe_no,
  output logic                  lbe_no,
  output logic                  ldac_o,
  output logic                  clr_no,
  output logic [DAC_BYTE_W-1:0] dac_data_o
);
  localparam int unsigned CntW = $clog2(MIN_STROBE + 1);
  localparam logic [CntW-1:0] CntMin = CntW'(MIN_STROBE);

  seq_state_e            state_q;
  logic [CntW-1:0]       cnt_q;
  logic                  sel_q;
  logic                  seen_q;
  logic [DAC_BYTE_W-1:0] data_q;
  logic                  live;
  logic                  done;

  // a clear starts one clock late, so it follows the write delayed by one
  assign live = (state_q == ST_CLR) ? valid_qq_i : cmd_i.valid;
  assign done = !live && (cnt_q >= CntMin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      seen_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      if (!cmd_i.valid) seen_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_i.valid && !seen_q) begin
            seen_q <= 1'b1;
            sel_q  <= cmd_i.sel;
            cnt_q  <= CntW'(1);
            unique case (cmd_i.op)
              OP_BYTE: begin
                state_q <= ST_BYTE;
                data_q  <= cmd_i.data;
              end
              OP_UPDATE: state_q <= ST_UPD;
              OP_CLEAR:  state_q <= ST_SETUP;
              default:   state_q <= ST_IDLE;
            endcase
          end
        end
        ST_SETUP: begin
          state_q <= ST_CLR;
          cnt_q   <= CntW'(1);
        end
        ST_BYTE, ST_UPD, ST_CLR: begin
          if (done) state_q <= ST_IDLE;
          else if (cnt_q < CntMin) cnt_q <= cnt_q + CntW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cs_no  = (state_q != ST_BYTE);
    hbe_no = !((state_q == ST_BYTE) && sel_q);
    ldac_o = (state_q == ST_UPD);
    clr_no = (state_q != ST_CLR);
    if (state_q == ST_SETUP || state_q == ST_CLR) lbe_no = sel_q;
    else lbe_no = !((state_q == ST_BYTE) && !sel_q);
  end

  assign dac_data_o = data_q;

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!cs_no, ldac_o, !clr_no}));
  assert_be_with_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hbe_no |-> (!cs_no && lbe_no));
  assert_min_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |=> !cs_no);
  assert_min_upd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ldac_o) |=> ldac_o);
  assert_min_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clr_no) |=> !clr_no);
  assert_clr_setup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clr_no) |-> $stable(lbe_no));
  assert_clr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_no && $past(!clr_no)) |-> $stable(lbe_no));
  assert_data_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(dac_data_o));
  assert_data_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldac_o || !clr_no) |-> $stable(dac_data_o));
endmodule

// File: rtl/io_dac_cmd_decoder.sv
module io_dac_cmd_decoder
  import io_dac_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BASE_ADDR  = 'h40,
  parameter int unsigned MIN_STROBE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              iorq_ni,
  input  logic              wr_ni,
  input  logic [7:0]        data_i,
  output logic              cs_no,
  output logic              hbe_no,
  output logic              lbe_no,
  output logic              ldac_o,
  output logic              clr_no,
  output logic [7:0]        dac_data_o,
  output logic              byte_mode_o
);
  cmd_t cmd_d;
  cmd_t cmd_q;
  logic valid_qq;

  io_dac_addr_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) i_decode (
    .addr_i  (addr_i),
    .iorq_ni (iorq_ni),
    .wr_ni   (wr_ni),
    .data_i  (data_i),
    .cmd_o   (cmd_d)
  );

  io_dac_bus_capture i_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_d),
    .cmd_q_o    (cmd_q),
    .valid_qq_o (valid_qq)
  );

  io_dac_strobe_seq #(
    .MIN_STROBE (MIN_STROBE)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_q),
    .valid_qq_i (valid_qq),
    .cs_no      (cs_no),
    .hbe_no     (hbe_no),
    .lbe_no     (lbe_no),
    .ldac_o     (ldac_o),
    .clr_no     (clr_no),
    .dac_data_o (dac_data_o)
  );

  assign byte_mode_o = 1'b1;

  assert_mode_tied_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_mode_o);
  assert_no_strobe_unqual_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cmd_q.valid) && !cmd_q.valid && !valid_qq) |-> (cs_no && !ldac_o) || $past(!cs_no || ldac_o));
endmodule

// File: tb/test_io_dac_cmd_decoder.sv
module test_io_dac_cmd_decoder;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BASE   = 'h40;
  localparam int unsigned MINS   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic iorq_n = 1'b1;
  logic wr_n = 1'b1;
  logic [7:0] data = '0;
  logic cs_n, hbe_n, lbe_n, ldac, clr_n, bmode;
  logic [7:0] dac_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] exp_data = 8'h00;

  always #4 clk = ~clk;

  io_dac_cmd_decoder #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .MIN_STROBE(MINS))
  i_io_dac_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .iorq_ni(iorq_n), .wr_ni(wr_n),
    .data_i(data), .cs_no(cs_n), .hbe_no(hbe_n), .lbe_no(lbe_n), .ldac_o(ldac),
    .clr_no(clr_n), .dac_data_o(dac_data), .byte_mode_o(bmode));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 none, 1 low byte, 2 high byte, 3 update, 4 clear unipolar, 5 clear bipolar
  function automatic int exp_kind(input logic [7:0] a, input logic iq, input logic w);
    if (iq || w) return 0;
    if (a[7:3] != BASE[7:3]) return 0;
    case (a[2:0])
      3'd0: return 1;
      3'd1: return 2;
      3'd2, 3'd3: return 3;
      3'd4: return 4;
      3'd5: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic do_cmd(input logic [7:0] a, input logic [7:0] d, input int n,
                        input logic iq, input logic w);
    int kind, len, win;
    int cs_cnt, cs_first, hbe_cnt, lbe_cs, lbe_lo, ldac_cnt, ldac_first;
    int clr_cnt, clr_first, clr_bad, data_bad, mode_bad;
    logic lbe_hist[0:31];
    kind = exp_kind(a, iq, w);
    len  = (n > int'(MINS)) ? n : int'(MINS);
    win  = n + int'(MINS) + 8;
    cs_cnt = 0; cs_first = 0; hbe_cnt = 0; lbe_cs = 0; lbe_lo = 0;
    ldac_cnt = 0; ldac_first = 0; clr_cnt = 0; clr_first = 0; clr_bad = 0;
    data_bad = 0; mode_bad = 0;
    for (int k = 0; k < 32; k++) lbe_hist[k] = 1'b1;
    @(negedge clk);
    addr = a; data = d; iorq_n = iq; wr_n = w;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (!cs_n) begin
        cs_cnt++;
        if (cs_first == 0) cs_first = i;
        if (dac_data != d) data_bad++;
      end
      if (!hbe_n) hbe_cnt++;
      if (!lbe_n) lbe_lo++;
      if (!lbe_n && !cs_n) lbe_cs++;
      if (ldac) begin ldac_cnt++; if (ldac_first == 0) ldac_first = i; end
      if (!clr_n) begin
        clr_cnt++;
        if (clr_first == 0) clr_first = i;
        if (lbe_n != (kind == 5)) clr_bad++;
      end
      if (!bmode) mode_bad++;
      lbe_hist[i] = lbe_n;
      if (i == n) begin
        iorq_n = 1'b1; wr_n = 1'b1; data = 8'($urandom);
      end
    end
    if (kind == 1 || kind == 2) exp_data = d;
    chk(mode_bad == 0, "R10 byte mode", mode_bad, 0);
    chk(dac_data == exp_data, "R9 data held", dac_data, exp_data);
    case (kind)
      0: begin
        chk(cs_cnt + ldac_cnt + clr_cnt == 0, "R1/R8 no strobe", cs_cnt + ldac_cnt + clr_cnt, 0);
        chk(lbe_lo + hbe_cnt == 0, "R8 enables idle", lbe_lo + hbe_cnt, 0);
      end
      1, 2: begin
        chk(cs_cnt == len, "R7 byte length", cs_cnt, len);
        chk(cs_first == 2, "R7 byte start", cs_first, 2);
        if (kind == 1) begin
          chk(lbe_cs == len && hbe_cnt == 0, "R2 low byte enables", lbe_cs, len);
        end else begin
          chk(hbe_cnt == len && lbe_lo == 0, "R3 high byte enables", hbe_cnt, len);
        end
        chk(data_bad == 0, "R9 data during load", data_bad, 0);
        chk(ldac_cnt + clr_cnt == 0, "R10 exclusive", ldac_cnt + clr_cnt, 0);
      end
      3: begin
        chk(ldac_cnt == len, "R4/R7 update length", ldac_cnt, len);
        chk(ldac_first == 2, "R7 update start", ldac_first, 2);
        chk(cs_cnt + hbe_cnt + lbe_lo + clr_cnt == 0, "R4 update only", cs_cnt + lbe_lo, 0);
      end
      default: begin
        chk(clr_cnt == len, "R5/R7 clear length", clr_cnt, len);
        chk(clr_first == 3, "R7 clear start", clr_first, 3);
        chk(clr_bad == 0, "R5 clear target", clr_bad, 0);
        chk(lbe_hist[2] == (kind == 5), "R6 target setup", lbe_hist[2], kind == 5);
        chk(lbe_hist[1] == 1'b1 && lbe_hist[3 + len] == 1'b1, "R6 lbe release",
            lbe_hist[3 + len], 1);
        chk(cs_cnt + ldac_cnt == 0, "R10 exclusive clear", cs_cnt + ldac_cnt, 0);
      end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(cs_n && hbe_n && lbe_n && clr_n && !ldac, "R11 reset strobes", ldac, 0);
    chk(dac_data == 8'h00, "R11 reset data", dac_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed
    do_cmd(8'h40, 8'hA5, 1, 1'b0, 1'b0);  // R2 min stretch
    do_cmd(8'h41, 8'h3C, 4, 1'b0, 1'b0);  // R3
    do_cmd(8'h42, 8'hFF, 1, 1'b0, 1'b0);  // R4
    do_cmd(8'h43, 8'h00, 3, 1'b0, 1'b0);  // R4
    do_cmd(8'h44, 8'h77, 1, 1'b0, 1'b0);  // R5 unipolar
    do_cmd(8'h45, 8'h11, 5, 1'b0, 1'b0);  // R5 bipolar
    do_cmd(8'h46, 8'h99, 2, 1'b0, 1'b0);  // R8
    do_cmd(8'h47, 8'h98, 2, 1'b0, 1'b0);  // R8
    do_cmd(8'h3F, 8'h97, 2, 1'b0, 1'b0);  // R8
    do_cmd(8'h48, 8'h96, 2, 1'b0, 1'b0);  // R8
    do_cmd(8'h40, 8'h55, 3, 1'b1, 1'b0);  // R1 iorq high
    do_cmd(8'h41, 8'h56, 3, 1'b0, 1'b1);  // R1 wr high
    // random
    for (int r = 0; r < 120; r++) begin
      logic [7:0] a;
      logic iq, w;
      a  = ($urandom % 4 != 0) ? 8'(BASE + ($urandom % 8)) : 8'($urandom);
      iq = ($urandom % 8 == 0);
      w  = ($urandom % 8 == 1);
      do_cmd(a, 8'($urandom), 1 + int'($urandom % 5), iq, w);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule